// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames on a single output line. Software-side logic places one character into a holding buffer through a write strobe; when the shifting stage is free and the transmitter is enabled, the character moves into the shifter and is sent as a start bit, the data bits least significant first, an optional parity bit and one or two stop bits. Because the holding buffer is separate from the shifter, the next character can be queued while the current frame is on the line, and consecutive frames follow each other with no idle time between them.

The frame layout is chosen at run time through three format inputs (character size, parity mode, stop count), which are captured at the moment each frame is loaded. Bit timing comes from an external one-cycle rate tick; every bit lasts a fixed number of such ticks (16 by default). Two flags report progress: one says the holding buffer can take a new character, the other says everything written has left the line.

Top module: `frame_tx`

## Requirements
- R1: After reset the line is 1, `buf_empty` is 1 and `tx_done` is 0, and the line is 1 whenever no frame is being sent.
- R2: A frame is a start bit of 0, then the data bits least significant first, then the parity bit when enabled, then the stop bits of 1; every bit holds for TICKS_PER_BIT baud ticks (16 by default).
- R3: `size_code` sets the data width: 3'b000 = 5, 3'b001 = 6, 3'b010 = 7, 3'b011 = 8, 3'b111 = 9 bits; reserved codes 3'b100, 3'b101 and 3'b110 send 8 bits. Bits of `wr_data` above the chosen width are not sent.
- R4: `par_code` 2'b10 appends even parity (the parity bit makes the count of ones in data plus parity even), 2'b11 appends odd parity, 2'b00 and the reserved 2'b01 send no parity bit.
- R5: `two_stop` = 0 sends one stop bit, 1 sends two.
- R6: A write is taken into the holding buffer only while `buf_empty` is 1; a write while it is 0 is dropped and never reaches the line.
- R7: A character moves into the shifter only while `tx_en` is 1 and no frame is in progress; while `tx_en` is 0 a queued character stays queued and the line stays 1.
- R8: `buf_empty` returns to 1 in the cycle the character moves into the shifter; a character queued during a frame starts its start bit directly after the last stop bit of that frame, with no idle bit time.
- R9: `tx_done` rises when the last stop bit ends while the holding buffer is empty, and falls at the next accepted write; it stays 0 across a back-to-back frame boundary.
- R10: The format inputs are captured when a frame is loaded; changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle rate pulse; TICKS_PER_BIT pulses make one bit |
| tx_en | input | 1 | Allows new characters to be loaded into the shifter |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Character to queue; bits above the chosen width are unused |
| size_code | input | 3 | Character size code |
| par_code | input | 2 | Parity mode code |
| two_stop | input | 1 | Stop count select |
| buf_empty | output | 1 | Holding buffer can take a write |
| tx_done | output | 1 | Last frame ended and nothing is queued |
| tx_line | output | 1 | Serial output line, idle high |

## Verification
The hardest situation to reach from the ports is a character queued while another frame is on the line, because its write must land after the holding buffer has drained into the shifter yet before the last stop bit ends. The bench reaches it by detecting the start bit of the first frame, which is the cycle in which the buffer is free again, and issuing the second write in parallel with the bit-by-bit check of the first frame, so that the start bit of the second frame must appear in the very cycle after the first frame's last stop bit. A dropped write is reached by holding `tx_en` low so the buffer stays full, and a mid-frame format change is driven in parallel with the waveform check of the frame it must not disturb.

// File: rtl/ftx_pkg.sv
// Shared definitions for the configurable serial transmitter.
// Assumes the character-size and parity encodings listed in the brief.
package ftx_pkg;

    // Widest character the format codes can select.
    localparam int DATA_W = 9;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSVD = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_mode_e;

    // Map a character-size code to a data width; reserved codes give 8.
    function automatic int unsigned char_width(input logic [2:0] code);
        case (code)
            3'b000:  return 5;
            3'b001:  return 6;
            3'b010:  return 7;
            3'b011:  return 8;
            3'b111:  return 9;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/ftx_hold_buf.sv
// Single-entry holding buffer in front of the shifter.
// Takes a write only while empty; empties when the shifter takes the entry.
// Assumes take is raised only while the buffer is full.
module ftx_hold_buf #(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          wr_ok,
    output logic          full,
    output logic [DW-1:0] data_q
);

    logic full_q;

    // A write is accepted only into an empty buffer.
    assign wr_ok = wr_en && !full_q;
    assign full  = full_q;

    // Capture accepted writes and release the entry when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (wr_ok) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end
    end

endmodule

// File: rtl/ftx_frame_build.sv
// Combinational frame assembler.
// Lays out start bit, masked data (LSB first), optional parity and stop
// bits into a vector sent from bit 0 upward, and reports its bit count.
// Positions above the frame are filled with 1 so the shifter idles high.
module ftx_frame_build
    import ftx_pkg::*;
#(
    parameter int DW      = 9,
    parameter int FRAME_W = DW + 4,
    parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DW-1:0]      data,
    input  logic [2:0]         size_code,
    input  logic [1:0]         par_code,
    input  logic               two_stop,
    output logic [FRAME_W-1:0] frame,
    output logic [CNT_W-1:0]   nbits
);

    par_mode_e   pmode;
    logic        par_on;
    logic        par_bit;
    int unsigned width;

    // Decode the run-time format fields.
    always_comb begin
        pmode  = par_mode_e'(par_code);
        par_on = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
        width  = char_width(size_code);
    end

    // Assemble the frame vector and its length.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        par_bit  = (pmode == PAR_ODD);
        for (int i = 0; i < DW; i++) begin
            if (i < int'(width)) begin
                frame[i+1] = data[i];
                par_bit    = par_bit ^ data[i];
            end
        end
        if (par_on) begin
            for (int k = 1; k < FRAME_W; k++) begin
                if (k == int'(width) + 1) frame[k] = par_bit;
            end
        end
        nbits = CNT_W'(1 + int'(width) + (par_on ? 1 : 0) + (two_stop ? 2 : 1));
    end

endmodule

// File: rtl/ftx_shifter.sv
// Bit-timing and shift stage.
// Loads a frame when the holding buffer is full, the transmitter is enabled
// and the line is free (or the last bit is ending), then shifts one bit
// every TICKS ticks. Also keeps the transmit-complete flag.
// Assumes tick is a one-cycle pulse and nbits_in is at least 1.
module ftx_shifter #(
    parameter int FRAME_W = 13,
    parameter int CNT_W   = 4,
    parameter int TICKS   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               tx_en,
    input  logic               buf_full,
    input  logic               wr_ok,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [CNT_W-1:0]   nbits_in,
    output logic               load_go,
    output logic               active,
    output logic               line,
    output logic               done
);

    localparam int TCW = (TICKS > 2) ? $clog2(TICKS) : 1;
    localparam logic [TCW-1:0] T_LAST = TCW'(TICKS - 1);

    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   left_q;
    logic [TCW-1:0]     tcnt_q;
    logic               active_q;
    logic               done_q;
    logic               bit_end;
    logic               frame_end;

    // Detect bit and frame boundaries, and decide on a load.
    always_comb begin
        bit_end   = active_q && tick && (tcnt_q == T_LAST);
        frame_end = bit_end && (left_q == CNT_W'(1));
        load_go   = buf_full && tx_en && (!active_q || frame_end);
    end

    // Shift register, bit counter and tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '1;
            left_q   <= '0;
            tcnt_q   <= '0;
            active_q <= 1'b0;
        end else if (load_go) begin
            sh_q     <= frame_in;
            left_q   <= nbits_in;
            tcnt_q   <= '0;
            active_q <= 1'b1;
        end else if (frame_end) begin
            sh_q     <= '1;
            left_q   <= '0;
            tcnt_q   <= '0;
            active_q <= 1'b0;
        end else if (bit_end) begin
            sh_q     <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q   <= left_q - CNT_W'(1);
            tcnt_q   <= '0;
        end else if (active_q && tick) begin
            tcnt_q   <= tcnt_q + TCW'(1);
        end
    end

    // Transmit-complete: set at a frame end with nothing queued, cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     done_q <= 1'b0;
        else if (wr_ok)                 done_q <= 1'b0;
        else if (frame_end && !buf_full) done_q <= 1'b1;
    end

    assign active = active_q;
    assign line   = sh_q[0];
    assign done   = done_q;

endmodule

// File: rtl/frame_tx.sv
// Configurable asynchronous serial transmitter, top level.
// Holding buffer -> frame assembler -> shift stage. Format inputs are read
// by the assembler at the cycle a frame is loaded.
// Assumes baud_tick is a one-cycle pulse from an external rate divider.
module frame_tx
    import ftx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        size_code,
    input  logic [1:0]        par_code,
    input  logic              two_stop,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              tx_line
);

    localparam int FRAME_W = DATA_W + 4;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic               wr_ok;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               load_go;
    logic               sh_active;
    logic [FRAME_W-1:0] frame_vec;
    logic [CNT_W-1:0]   frame_len;

    ftx_hold_buf #(.DW(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (load_go),
        .wr_ok   (wr_ok),
        .full    (hold_full),
        .data_q  (hold_data)
    );

    ftx_frame_build #(.DW(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
        .data      (hold_data),
        .size_code (size_code),
        .par_code  (par_code),
        .two_stop  (two_stop),
        .frame     (frame_vec),
        .nbits     (frame_len)
    );

    ftx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .TICKS(TICKS_PER_BIT)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .tx_en    (tx_en),
        .buf_full (hold_full),
        .wr_ok    (wr_ok),
        .frame_in (frame_vec),
        .nbits_in (frame_len),
        .load_go  (load_go),
        .active   (sh_active),
        .line     (tx_line),
        .done     (tx_done)
    );

    assign buf_empty = !hold_full;

endmodule

// File: rtl/ftx_checker.sv
// Property checker for frame_tx, attached by bind below.
// Observes ports and the handover signals between buffer and shifter.
module ftx_checker #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          tx_en,
    input logic          wr_en,
    input logic          buf_empty,
    input logic          tx_done,
    input logic          tx_line,
    input logic          active,
    input logic          take,
    input logic [DW-1:0] hold_q
);

    // R1: the line sits high whenever no frame is in progress
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> tx_line);

    // R2: the line only moves on a tick or at a load
    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick && !take) |=> $stable(tx_line));

    // R6: a write into a full buffer leaves its contents untouched
    assert_drop_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !buf_empty) |=> $stable(hold_q));

    // R6: a write into an empty buffer fills it
    assert_accept_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_empty) |=> !buf_empty);

    // R7: a fresh frame only starts after an enabled cycle
    assert_start_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(tx_en));

    // R8: the buffer reads empty right after its entry is taken
    assert_empty_on_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> buf_empty);

    // R9: complete implies nothing queued and nothing on the line
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (buf_empty && !active));

endmodule

bind frame_tx ftx_checker #(.DW(ftx_pkg::DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .tx_en     (tx_en),
    .wr_en     (wr_en),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .tx_line   (tx_line),
    .active    (sh_active),
    .take      (load_go),
    .hold_q    (hold_data)
);

// File: tb/sim_frame_tx.sv
// Self-checking bench for frame_tx: sweeps every size, parity and stop code,
// then targets dropped writes, enable gating, back-to-back frames, mid-frame
// format changes and a slower tick rate.
module sim_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic [2:0] size_code = 3'b011;
    logic [1:0] par_code = 2'b00;
    logic       two_stop = 1'b0;
    logic       buf_empty;
    logic       tx_done;
    logic       tx_line;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 1;
    int tick_ph  = 0;
    bit finished = 0;

    frame_tx #(.TICKS_PER_BIT(TPB)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .tx_en     (tx_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .size_code (size_code),
        .par_code  (par_code),
        .two_stop  (two_stop),
        .buf_empty (buf_empty),
        .tx_done   (tx_done),
        .tx_line   (tx_line)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Tick source: one pulse every tick_div cycles.
    always @(posedge clk) begin
        if (tick_ph + 1 >= tick_div) begin
            tick_ph   <= 0;
            baud_tick <= 1'b1;
        end else begin
            tick_ph   <= tick_ph + 1;
            baud_tick <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected data width from the size code.
    function automatic int exp_width(input int sz);
        if (sz < 4)  return 5 + sz;
        if (sz == 7) return 9;
        return 8;
    endfunction

    function automatic int exp_nbits(input int sz, input int pc, input int st);
        return 1 + exp_width(sz) + ((pc >= 2) ? 1 : 0) + (st + 1);
    endfunction

    // Expected level of frame bit k.
    function automatic int exp_bit(input int k, input int d, input int sz,
                                   input int pc, input int st);
        int w;
        int ones;
        w = exp_width(sz);
        if (k == 0) return 0;
        if (k <= w) return (d >> (k - 1)) & 1;
        if (pc >= 2 && k == w + 1) begin
            ones = 0;
            for (int i = 0; i < w; i++) ones += (d >> i) & 1;
            return (pc == 3) ? ((ones + 1) % 2) : (ones % 2);
        end
        return 1;
    endfunction

    function automatic string bit_req(input int k, input int sz, input int pc);
        int w;
        w = exp_width(sz);
        if (k == 0) return "R2 start";
        if (k <= w) return "R3 data";
        if (pc >= 2 && k == w + 1) return "R4 parity";
        return "R5 stop";
    endfunction

    task automatic write_char(input int d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = 9'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_start();
        int n;
        n = 0;
        while (tx_line !== 1'b0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(tx_line === 1'b0, "R2", "start bit seen", int'(tx_line), 0);
    endtask

    // Called at the negedge of the first start-bit cycle; returns at the
    // negedge just after the last stop bit.
    task automatic check_frame(input int d, input int sz, input int pc, input int st);
        int nb;
        int per;
        int bad;
        int lvl;
        nb  = exp_nbits(sz, pc, st);
        per = TPB * tick_div;
        for (int k = 0; k < nb; k++) begin
            bad = 0;
            lvl = exp_bit(k, d, sz, pc, st);
            for (int c = 0; c < per; c++) begin
                if (tick_div == 1 || c == per / 2) begin
                    if (int'(tx_line) != lvl) bad++;
                end
                @(negedge clk);
            end
            chk(bad == 0, bit_req(k, sz, pc), $sformatf("bit %0d of 0x%0h", k, d),
                (bad == 0) ? lvl : 1 - lvl, lvl);
        end
    endtask

    task automatic check_done_end();
        chk(tx_done === 1'b1, "R9", "done after frame", int'(tx_done), 1);
        chk(tx_line === 1'b1, "R1", "idle after frame", int'(tx_line), 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired (all requirements): actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int d;
        int quiet_bad;
        tx_en = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_line === 1'b1, "R1", "line after reset", int'(tx_line), 1);
        chk(buf_empty === 1'b1, "R1", "buf_empty after reset", int'(buf_empty), 1);
        chk(tx_done === 1'b0, "R1", "tx_done after reset", int'(tx_done), 0);

        // R2 R3 R4 R5 R9: sweep every format code with several characters
        for (int sz = 0; sz < 8; sz++) begin
            for (int pc = 0; pc < 4; pc++) begin
                for (int st = 0; st < 2; st++) begin
                    for (int v = 0; v < 3; v++) begin
                        d = (sz * 53 + pc * 29 + st * 71 + v * 137 + 165) % 512;
                        size_code = 3'(sz);
                        par_code  = 2'(pc);
                        two_stop  = st[0];
                        write_char(d);
                        chk(tx_done === 1'b0, "R9", "done cleared by write", int'(tx_done), 0);
                        wait_start();
                        check_frame(d, sz, pc, st);
                        check_done_end();
                    end
                end
            end
        end

        // R6 R7: disabled transmitter keeps its entry and drops a second write
        size_code = 3'b011; par_code = 2'b00; two_stop = 1'b0;
        tx_en = 1'b0;
        write_char(9'h0C3);
        chk(buf_empty === 1'b0, "R6", "buffer full after write", int'(buf_empty), 0);
        write_char(9'h05A);
        quiet_bad = 0;
        for (int c = 0; c < 3 * TPB; c++) begin
            if (tx_line !== 1'b1) quiet_bad++;
            @(negedge clk);
        end
        chk(quiet_bad == 0, "R7", "line idle while disabled", quiet_bad, 0);
        chk(buf_empty === 1'b0, "R7", "entry held while disabled", int'(buf_empty), 0);
        tx_en = 1'b1;
        wait_start();
        check_frame(9'h0C3, 3, 0, 0);
        check_done_end();

        // R8 R9: second character queued during the first frame, no gap
        size_code = 3'b011; par_code = 2'b10; two_stop = 1'b1;
        write_char(9'h0A7);
        wait_start();
        chk(buf_empty === 1'b1, "R8", "buffer empty at load", int'(buf_empty), 1);
        fork
            check_frame(9'h0A7, 3, 2, 1);
            write_char(9'h031);
        join
        chk(tx_done === 1'b0, "R9", "done low at back-to-back boundary", int'(tx_done), 0);
        chk(tx_line === 1'b0, "R8", "next start bit without gap", int'(tx_line), 0);
        check_frame(9'h031, 3, 2, 1);
        check_done_end();

        // R10: format changes during a frame do not affect it
        size_code = 3'b111; par_code = 2'b11; two_stop = 1'b1;
        write_char(9'h1B4);
        wait_start();
        fork
            check_frame(9'h1B4, 7, 3, 1);
            begin
                @(negedge clk);
                @(negedge clk);
                size_code = 3'b000; par_code = 2'b00; two_stop = 1'b0;
            end
        join
        check_done_end();

        // R2: bit length follows the tick, not the clock
        @(negedge clk);
        tick_div = 3;
        size_code = 3'b010; par_code = 2'b10; two_stop = 1'b0;
        write_char(9'h05D);
        wait_start();
        check_frame(9'h05D, 2, 2, 0);
        repeat (4) @(negedge clk);
        check_done_end();

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule